// File: doc/BRIEF.md
# Shared-Period Dual PWM Timer

This block generates two pulse-width-modulated waveforms that share a single period. A master down-counter defines the period. Each time it wraps through zero it produces a period pulse, and it also produces one right after a start. Two slave down-counters are reloaded by that pulse. Each slave holds its output at the active level until its counter has run out, and then waits for the next period pulse.

All counting advances only on cycles where the count-clock enable is high. Software starts and stops all three channels together through single-cycle trigger inputs. It can write the period and duty values at any time, and those values are picked up at the next period pulse. Output polarity can only be changed while the timer is stopped. Output enable and software level can be changed at any time. When a slave's output enable is low, its output drives the software-written level. All three counter values are always visible on readback ports.

Top module: `pwm_mslave_timer`

## Requirements
- R1: While reset is asserted and straight after it, all counters read zero, both outputs are low and the period interrupt is low.
- R2: The first count-clock tick after a start trigger produces a period pulse. In the cycle after that tick, the interrupt is high, the master counter holds the period value and each slave counter holds its duty value.
- R3: With period value P, a period pulse occurs every P+1 ticks. The interrupt is high for exactly the one cycle after the pulse tick. The master counter reads P minus the number of ticks since the last pulse.
- R4: After each pulse, slave i is active for D_i ticks. Its counter reads D_i minus the ticks since the pulse, stops at zero, and stays there until the next pulse. The active level is high when polarity bit i is 1 and low when it is 0.
- R5: A duty value of zero keeps the output inactive for the whole period. A duty value greater than P keeps it active without a break.
- R6: Period and duty writes made during a run do not alter the current period. They take effect at the next period pulse.
- R7: After a stop trigger, all counters keep their values, the outputs keep their levels and no interrupt is raised. If start and stop arrive together, stop wins.
- R8: A polarity write (cfg_we_i) is ignored while running. It is accepted while stopped and takes effect on the output at once.
- R9: When output-enable bit i is 0, pwm_o[i] equals software level bit i, whatever the counter state.
- R10: On cycles with cnt_en_i low, no counter advances and no period pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable (one tick per high cycle) |
| start_i | input | 1 | Start trigger for all channels |
| stop_i | input | 1 | Stop trigger for all channels |
| period_we_i | input | 1 | Period register write strobe |
| period_i | input | 16 | Period value |
| duty_we_i | input | 2 | Per-slave duty write strobes |
| duty_i | input | 16 | Duty value (shared data) |
| cfg_we_i | input | 1 | Polarity write strobe (stopped only) |
| pol_i | input | 2 | Active level per slave, 1 = high |
| lvl_we_i | input | 1 | Output-enable / software-level write strobe |
| oe_i | input | 2 | Per-slave output enable |
| sw_lvl_i | input | 2 | Per-slave software output level |
| pwm_o | output | 2 | PWM outputs |
| period_irq_o | output | 1 | Period interrupt, one cycle per pulse |
| mst_cnt_o | output | 16 | Master counter readback |
| slv_cnt_o | output | 32 | Slave counters, slave 0 in bits 15:0 |

## Verification
The hardest case to reach is a period or duty write that arrives in the middle of a running period. To be observed at all, the old period must finish exactly on its old schedule before the new values appear. The stimulus starts the timer, waits a fixed number of ticks, and writes a shorter period and duty in that same phase. The checks then confirm that the master still reaches zero on the old count and that the next pulse loads the new values. A second hard case is a polarity write made while running. The stimulus uses a duty larger than the period so that the output is held steady. Any accepted polarity write would then show at once on the output.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W = 16;
  localparam int N_SLV = 2;

  function automatic logic drive_level(input logic act, input logic pol,
                                       input logic oe, input logic sw);
    if (!oe) return sw;
    return act ? pol : ~pol;
  endfunction
endpackage

// File: rtl/pwm_mst_chan.sv
module pwm_mst_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         start_i,
  input  logic [W-1:0] period_i,
  output logic         pulse_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         kick_q;

  // pulse on first tick after start, then on every zero
  assign pulse_o = run_i & tick_i & (kick_q | (cnt_q == '0));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      if (start_i)      kick_q <= 1'b1;
      else if (pulse_o) kick_q <= 1'b0;
      if (pulse_o)                cnt_q <= period_i;
      else if (run_i && tick_i)   cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  mst_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !kick_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R7
  mst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  // R10
  mst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_slv_chan.sv
module pwm_slv_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] duty_i,
  output logic         act_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         act_q;

  assign act_o = act_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= duty_i;
      act_q <= (duty_i != '0);
    end else if (run_i && tick_i && act_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == W'(1)) act_q <= 1'b0;
    end
  end

  // R4
  slv_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> cnt_q != '0);
  // R4
  slv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !load_i) |=> !act_q);
  // R4
  slv_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q == W'(1) && run_i && tick_i && !load_i) |=> !act_q && cnt_q == '0);
endmodule

// File: rtl/pwm_mslave_timer.sv
module pwm_mslave_timer
  import pwm_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int NS = N_SLV
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            period_we_i,
  input  logic [W-1:0]    period_i,
  input  logic [NS-1:0]   duty_we_i,
  input  logic [W-1:0]    duty_i,
  input  logic            cfg_we_i,
  input  logic [NS-1:0]   pol_i,
  input  logic            lvl_we_i,
  input  logic [NS-1:0]   oe_i,
  input  logic [NS-1:0]   sw_lvl_i,
  output logic [NS-1:0]   pwm_o,
  output logic            period_irq_o,
  output logic [W-1:0]    mst_cnt_o,
  output logic [NS*W-1:0] slv_cnt_o
);
  logic          run_q, irq_q, pulse;
  logic [W-1:0]  period_q;
  logic [NS-1:0] pol_q, oe_q, sw_q, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      irq_q    <= 1'b0;
      period_q <= '0;
      pol_q    <= '1;
      oe_q     <= '0;
      sw_q     <= '0;
    end else begin
      if (stop_i)       run_q <= 1'b0;   // stop wins over start
      else if (start_i) run_q <= 1'b1;
      irq_q <= pulse;
      if (period_we_i)          period_q <= period_i;
      if (cfg_we_i && !run_q)   pol_q    <= pol_i;
      if (lvl_we_i) begin
        oe_q <= oe_i;
        sw_q <= sw_lvl_i;
      end
    end
  end

  pwm_mst_chan #(.W(W)) u_mst (
    .clk_i, .rst_ni,
    .tick_i  (cnt_en_i),
    .run_i   (run_q),
    .start_i (start_i & ~stop_i),
    .period_i(period_q),
    .pulse_o (pulse),
    .cnt_o   (mst_cnt_o)
  );

  for (genvar i = 0; i < NS; i++) begin : g_slv
    logic [W-1:0] duty_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            duty_q <= '0;
      else if (duty_we_i[i])  duty_q <= duty_i;
    end

    pwm_slv_chan #(.W(W)) u_slv (
      .clk_i, .rst_ni,
      .tick_i(cnt_en_i),
      .run_i (run_q),
      .load_i(pulse),
      .duty_i(duty_q),
      .act_o (act[i]),
      .cnt_o (slv_cnt_o[i*W +: W])
    );

    assign pwm_o[i] = drive_level(act[i], pol_q[i], oe_q[i], sw_q[i]);
  end

  assign period_irq_o = irq_q;

  // R3
  irq_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_irq_o |-> mst_cnt_o == $past(period_q));
  // R7
  irq_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !period_irq_o);
  // R8
  pol_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(pol_q));
endmodule

// File: tb/tb_pwm_mslave_timer.sv
module tb_pwm_mslave_timer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cnt_en_i = 1'b1, start_i = 1'b0, stop_i = 1'b0, period_we_i = 1'b0;
  logic cfg_we_i = 1'b0, lvl_we_i = 1'b0;
  logic [15:0] period_i = '0, duty_i = '0;
  logic [1:0] duty_we_i = '0, pol_i = '0, oe_i = '0, sw_lvl_i = '0;
  logic [1:0] pwm_o;
  logic period_irq_o;
  logic [15:0] mst_cnt_o;
  logic [31:0] slv_cnt_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_mslave_timer dut (.*, .clk_i(clk));

  // {period, duty0, duty1, polarity}
  localparam logic [63:0] VEC [5] = '{
    {16'd5, 16'd2, 16'd4, 16'd3},
    {16'd3, 16'd0, 16'd1, 16'd1},
    {16'd4, 16'd9, 16'd4, 16'd3},
    {16'd0, 16'd1, 16'd0, 16'd3},
    {16'd6, 16'd6, 16'd7, 16'd0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_period(input int p);
    period_i = 16'(p); period_we_i = 1'b1; step(); period_we_i = 1'b0;
  endtask

  task automatic wr_duty(input int i, input int d);
    duty_i = 16'(d); duty_we_i = 2'b01 << i; step(); duty_we_i = '0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; step(); stop_i = 1'b0;
  endtask

  initial begin
    logic [15:0] m_hold, s_hold;
    logic [1:0]  p_hold;
    repeat (3) step();
    // R1 reset state
    chk("R1 pwm", pwm_o, 0);
    chk("R1 irq", period_irq_o, 0);
    chk("R1 mst_cnt", mst_cnt_o, 0);
    chk("R1 slv_cnt", slv_cnt_o, 0);
    rst_ni = 1'b1;
    step();
    chk("R1 pwm after release", pwm_o, 0);
    oe_i = 2'b11; lvl_we_i = 1'b1; step(); lvl_we_i = 1'b0;

    // R2/R3/R4/R5 vector walk
    for (int v = 0; v < 5; v++) begin
      int p, d[2], pl;
      p = int'(VEC[v][63:48]); d[0] = int'(VEC[v][47:32]);
      d[1] = int'(VEC[v][31:16]); pl = int'(VEC[v][15:0]);
      wr_period(p); wr_duty(0, d[0]); wr_duty(1, d[1]);
      pol_i = 2'(pl); cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
      pulse_start();
      for (int j = 0; j < 2 * (p + 1) + 2; j++) begin
        int ph, e;
        step();
        ph = j % (p + 1);
        chk($sformatf("R2/R3 irq v%0d j%0d", v, j), period_irq_o, ph == 0);
        chk($sformatf("R3 mst_cnt v%0d j%0d", v, j), mst_cnt_o, p - ph);
        for (int i = 0; i < 2; i++) begin
          e = (d[i] > ph) ? pl[i] : !pl[i];
          chk($sformatf("R4/R5 pwm%0d v%0d j%0d", i, v, j), pwm_o[i], e);
          chk($sformatf("R4 slv_cnt%0d v%0d j%0d", i, v, j),
              slv_cnt_o[i*16 +: 16], (d[i] > ph) ? d[i] - ph : 0);
        end
      end
      pulse_stop();
    end

    // R6 mid-run reload: P=4, D0=2 -> P=2, D0=1 written at tick 2
    wr_period(4); wr_duty(0, 2);
    pol_i = 2'b11; cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
    pulse_start();
    step(); step();
    period_i = 16'd2; period_we_i = 1'b1; duty_i = 16'd1; duty_we_i = 2'b01;
    step();
    period_we_i = 1'b0; duty_we_i = '0;
    chk("R6 pwm0 old duty j2", pwm_o[0], 0);
    step(); step();
    chk("R6 mst_cnt old period j4", mst_cnt_o, 0);
    step();
    chk("R6 irq j5", period_irq_o, 1);
    chk("R6 mst_cnt new period j5", mst_cnt_o, 2);
    chk("R6 pwm0 new duty j5", pwm_o[0], 1);
    step();
    chk("R6 pwm0 new duty j6", pwm_o[0], 0);
    chk("R6 irq j6", period_irq_o, 0);
    step(); step();
    chk("R6 irq new period j8", period_irq_o, 1);

    // R7 stop holds everything
    step();
    pulse_stop();
    m_hold = mst_cnt_o; s_hold = slv_cnt_o[15:0]; p_hold = pwm_o;
    repeat (4) step();
    chk("R7 mst_cnt held", mst_cnt_o, m_hold);
    chk("R7 slv_cnt held", slv_cnt_o[15:0], s_hold);
    chk("R7 pwm held", pwm_o, p_hold);
    chk("R7 no irq", period_irq_o, 0);
    // R7 start and stop together: stop wins
    start_i = 1'b1; stop_i = 1'b1; step(); start_i = 1'b0; stop_i = 1'b0;
    repeat (3) step();
    chk("R7 start+stop stays stopped", mst_cnt_o, m_hold);

    // R8 polarity locked while running (duty > period: steady active)
    wr_period(3); wr_duty(0, 9);
    pulse_start(); step(); step();
    chk("R8 pwm0 active high", pwm_o[0], 1);
    pol_i = 2'b10; cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
    step();
    chk("R8 pol write ignored while running", pwm_o[0], 1);

    // R10 count enable low freezes counting
    cnt_en_i = 1'b0;
    step();
    m_hold = mst_cnt_o;
    repeat (6) step();
    chk("R10 mst_cnt frozen", mst_cnt_o, m_hold);
    chk("R10 no irq", period_irq_o, 0);
    cnt_en_i = 1'b1;
    step();
    chk("R10 resumes", mst_cnt_o != m_hold, 1);

    pulse_stop();
    pol_i = 2'b10; cfg_we_i = 1'b1; step(); cfg_we_i = 1'b0;
    chk("R8 pol write accepted when stopped", pwm_o[0], 0);

    // R9 software level when output disabled
    oe_i = 2'b00; sw_lvl_i = 2'b10; lvl_we_i = 1'b1; step(); lvl_we_i = 1'b0;
    chk("R9 sw level 10", pwm_o, 2);
    oe_i = 2'b00; sw_lvl_i = 2'b01; lvl_we_i = 1'b1; step(); lvl_we_i = 1'b0;
    chk("R9 sw level 01", pwm_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule